// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register Slice

This block is the register slice of one DMA channel. It sits between a simple 32-bit register bus and the channel's transfer engine. Software uses it to start and stop the channel, to see and acknowledge completion and error events, and to choose which of those events may drive the interrupt line. It also reads the engine's current positions and its activity counts. The engine supplies one-cycle event pulses: done, a small error vector, byte increments, and source and destination interrupt events. In return the block drives the interrupt line and the channel-enable level.

Each register sits at a 4-bit word index, and read data is combinational from that index. Read side effects happen on the clock edge while `rd_en` is high. Interrupt status bits are sticky and are cleared by writing ones. The mask has inverted polarity: a 1 blocks an interrupt. Software never writes the mask directly. It changes the mask through an unmask register and a block register. The two event counters clear themselves when read. The byte total clears only when software writes back the exact value it holds.

Top module: `dmach_regs`

## Requirements
- R1: After reset the status reads 0, the mask reads all ones (`0xF` with the default 3 error bits), and the control register, byte total and both event counters read 0. `irq` and `ch_enable` are low.
- R2: Status sits at index 0. Bit 0 is done and bits 1 upward are the error bits. Writing 1 to a status bit clears it and writing 0 leaves it alone. Write bits above the defined interrupt bits have no effect, and those bits always read 0.
- R3: A done or error pulse sets its status bit on the next edge. When a pulse and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R4: `irq` is high exactly when some status bit is set whose mask bit is 0. A mask bit of 1 means the interrupt is disabled.
- R5: Writing to the unmask register (index 2) clears the mask bits where the data has ones and leaves the other mask bits unchanged. The mask reads at index 1. The unmask register reads 0.
- R6: Writing to the block register (index 3) sets the mask bits where the data has ones and leaves the other mask bits unchanged. It reads 0.
- R7: At control (index 4), a write with bit 0 set raises `ch_enable` and a write with bit 1 set lowers it; bit 1 wins when both are set. A done pulse lowers the enable, except when a start write lands in the same cycle. The control register reads `ch_enable` in bit 0.
- R8: The source (index 6) and destination (index 7) event counters count one per event cycle and saturate at their maximum (255 by default). A read returns the count and zeroes the counter. An event in the same cycle as the read is kept as the first count of the next period.
- R9: The byte total (index 5) adds `byte_inc` on every cycle with `byte_vld` high. A write whose data equals the current total clears it, and any other write is ignored. An increment in the clearing cycle becomes the new total.
- R10: Current addresses read as low then high 32-bit halves: source payload at 8/9, destination payload at 10/11, source descriptor at 12/13, destination descriptor at 14/15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| ev_done | input | 1 | Transfer complete pulse |
| ev_err | input | ERR_W | Error pulses, one per cause |
| src_irq_ev | input | 1 | Source-side interrupt event |
| dst_irq_ev | input | 1 | Destination-side interrupt event |
| byte_vld | input | 1 | Byte increment valid |
| byte_inc | input | INC_W | Bytes moved this cycle |
| cur_src_pay | input | 64 | Current source payload address |
| cur_dst_pay | input | 64 | Current destination payload address |
| cur_src_dscr | input | 64 | Current source descriptor address |
| cur_dst_dscr | input | 64 | Current destination descriptor address |
| irq | output | 1 | Interrupt request |
| ch_enable | output | 1 | Channel enable level |

## Verification
The assertions take a few things for granted about the inputs. Writes and reads come one at a time, so the unmask and block registers are never written in the same cycle. Event inputs are single-cycle pulses sampled at the clock edge. The stimulus keeps within these limits by driving the bus only through write and read tasks that change inputs at the falling edge. It raises events for whole cycles only, and it overlaps an event with a bus access only in the coincidence cases that R3, R7, R8 and R9 define.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [3:0] {
    RG_STAT  = 4'd0,
    RG_MASK  = 4'd1,
    RG_UNMSK = 4'd2,
    RG_BLOCK = 4'd3,
    RG_CTRL  = 4'd4,
    RG_BYTES = 4'd5,
    RG_SCNT  = 4'd6,
    RG_DCNT  = 4'd7,
    RG_SPL   = 4'd8,
    RG_SPH   = 4'd9,
    RG_DPL   = 4'd10,
    RG_DPH   = 4'd11,
    RG_SDL   = 4'd12,
    RG_SDH   = 4'd13,
    RG_DDL   = 4'd14,
    RG_DDH   = 4'd15
  } reg_e;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_HALT_BIT = 1;
endpackage

// File: rtl/dmach_irq_unit.sv
module dmach_irq_unit #(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] ev_set,
  input  logic [NIRQ-1:0] w1c,
  input  logic [NIRQ-1:0] unmask,
  input  logic [NIRQ-1:0] setmask,
  output logic [NIRQ-1:0] stat_q,
  output logic [NIRQ-1:0] mask_q,
  output logic            irq_o
);
  // events are OR-ed in after the clear so that a coincident event survives
  function automatic logic [NIRQ-1:0] next_stat(logic [NIRQ-1:0] cur,
                                                logic [NIRQ-1:0] clr,
                                                logic [NIRQ-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [NIRQ-1:0] next_mask(logic [NIRQ-1:0] cur,
                                                logic [NIRQ-1:0] en,
                                                logic [NIRQ-1:0] dis);
    return (cur & ~en) | dis;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= next_stat(stat_q, w1c, ev_set);
      mask_q <= next_mask(mask_q, unmask, setmask);
    end
  end

  assign irq_o = |(stat_q & ~mask_q);
endmodule

// File: rtl/dmach_evt_cnt.sv
module dmach_evt_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic         rd_clr,
  output logic [W-1:0] cnt_q
);
  function automatic logic [W-1:0] bump(logic [W-1:0] c, logic e);
    if (e && (c != {W{1'b1}})) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (rd_clr) cnt_q <= {{(W-1){1'b0}}, ev};
    else             cnt_q <= bump(cnt_q, ev);
  end
endmodule

// File: rtl/dmach_byte_acc.sv
module dmach_byte_acc #(
  parameter int W     = 32,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_vld,
  input  logic [INC_W-1:0] inc,
  input  logic             clr,
  output logic [W-1:0]     total_q
);
  function automatic logic [W-1:0] add_bytes(logic [W-1:0] c, logic v,
                                             logic [INC_W-1:0] i);
    return v ? c + W'(i) : c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   total_q <= '0;
    else if (clr) total_q <= add_bytes('0, inc_vld, inc);
    else          total_q <= add_bytes(total_q, inc_vld, inc);
  end
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int ERR_W  = 3,
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 32,
  parameter int INC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              ev_done,
  input  logic [ERR_W-1:0]  ev_err,
  input  logic              src_irq_ev,
  input  logic              dst_irq_ev,
  input  logic              byte_vld,
  input  logic [INC_W-1:0]  byte_inc,
  input  logic [63:0]       cur_src_pay,
  input  logic [63:0]       cur_dst_pay,
  input  logic [63:0]       cur_src_dscr,
  input  logic [63:0]       cur_dst_dscr,
  output logic              irq,
  output logic              ch_enable
);
  localparam int NIRQ = 1 + ERR_W;

  // decoded accesses, named for the checker
  logic wr_stat, wr_unmsk, wr_block, wr_ctrl, wr_bytes;
  logic rd_src, rd_dst, go_wr, halt_wr, byte_clr;
  logic [NIRQ-1:0] ev_vec, w1c_vec, unmask_vec, setmask_vec;
  logic [NIRQ-1:0] stat_q, mask_q;
  logic [CNT_W-1:0] cnt_src, cnt_dst;
  logic [BYTE_W-1:0] total_q;

  assign wr_stat  = wr_en && (addr == RG_STAT);
  assign wr_unmsk = wr_en && (addr == RG_UNMSK);
  assign wr_block = wr_en && (addr == RG_BLOCK);
  assign wr_ctrl  = wr_en && (addr == RG_CTRL);
  assign wr_bytes = wr_en && (addr == RG_BYTES);
  assign rd_src   = rd_en && (addr == RG_SCNT);
  assign rd_dst   = rd_en && (addr == RG_DCNT);

  assign go_wr    = wr_ctrl && wdata[CMD_GO_BIT];
  assign halt_wr  = wr_ctrl && wdata[CMD_HALT_BIT];
  assign byte_clr = wr_bytes && (wdata[BYTE_W-1:0] == total_q);

  assign ev_vec      = {ev_err, ev_done};
  assign w1c_vec     = wr_stat  ? wdata[NIRQ-1:0] : '0;
  assign unmask_vec  = wr_unmsk ? wdata[NIRQ-1:0] : '0;
  assign setmask_vec = wr_block ? wdata[NIRQ-1:0] : '0;

  dmach_irq_unit #(.NIRQ(NIRQ)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_set (ev_vec),
    .w1c    (w1c_vec),
    .unmask (unmask_vec),
    .setmask(setmask_vec),
    .stat_q (stat_q),
    .mask_q (mask_q),
    .irq_o  (irq)
  );

  dmach_evt_cnt #(.W(CNT_W)) u_scnt (
    .clk(clk), .rst_n(rst_n), .ev(src_irq_ev), .rd_clr(rd_src), .cnt_q(cnt_src)
  );

  dmach_evt_cnt #(.W(CNT_W)) u_dcnt (
    .clk(clk), .rst_n(rst_n), .ev(dst_irq_ev), .rd_clr(rd_dst), .cnt_q(cnt_dst)
  );

  dmach_byte_acc #(.W(BYTE_W), .INC_W(INC_W)) u_bytes (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_vld(byte_vld),
    .inc    (byte_inc),
    .clr    (byte_clr),
    .total_q(total_q)
  );

  // stop beats start, start beats completion
  always_ff @(posedge clk) begin
    if (!rst_n)       ch_enable <= 1'b0;
    else if (halt_wr) ch_enable <= 1'b0;
    else if (go_wr)   ch_enable <= 1'b1;
    else if (ev_done) ch_enable <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RG_STAT:  rdata[NIRQ-1:0]   = stat_q;
      RG_MASK:  rdata[NIRQ-1:0]   = mask_q;
      RG_CTRL:  rdata[0]          = ch_enable;
      RG_BYTES: rdata[BYTE_W-1:0] = total_q;
      RG_SCNT:  rdata[CNT_W-1:0]  = cnt_src;
      RG_DCNT:  rdata[CNT_W-1:0]  = cnt_dst;
      RG_SPL:   rdata = cur_src_pay[31:0];
      RG_SPH:   rdata = cur_src_pay[63:32];
      RG_DPL:   rdata = cur_dst_pay[31:0];
      RG_DPH:   rdata = cur_dst_pay[63:32];
      RG_SDL:   rdata = cur_src_dscr[31:0];
      RG_SDH:   rdata = cur_src_dscr[63:32];
      RG_DDL:   rdata = cur_dst_dscr[31:0];
      RG_DDH:   rdata = cur_dst_dscr[63:32];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmach_regs_chk.sv
module dmach_regs_chk #(
  parameter int NIRQ  = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NIRQ-1:0]  ev_vec,
  input logic [NIRQ-1:0]  w1c_vec,
  input logic [NIRQ-1:0]  unmask_vec,
  input logic [NIRQ-1:0]  setmask_vec,
  input logic [NIRQ-1:0]  stat_q,
  input logic [NIRQ-1:0]  mask_q,
  input logic             irq,
  input logic             ch_enable,
  input logic             ev_done,
  input logic             go_wr,
  input logic             halt_wr,
  input logic             rd_src,
  input logic             src_irq_ev,
  input logic [CNT_W-1:0] cnt_src
);
  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|w1c_vec) |=> ((stat_q & $past(w1c_vec & ~ev_vec)) == '0));

  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> ((stat_q & $past(ev_vec)) == $past(ev_vec)));

  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

  a_r5_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|unmask_vec) |=> ((mask_q & $past(unmask_vec)) == '0));

  a_r6_block_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|setmask_vec) |=> ((mask_q & $past(setmask_vec)) == $past(setmask_vec)));

  a_r7_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable && ev_done && !go_wr && !halt_wr) |=> !ch_enable);

  a_r7_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    halt_wr |=> !ch_enable);

  a_r8_read_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src && !src_irq_ev) |=> (cnt_src == '0));
endmodule

bind dmach_regs dmach_regs_chk #(.NIRQ(NIRQ), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_vec     (ev_vec),
  .w1c_vec    (w1c_vec),
  .unmask_vec (unmask_vec),
  .setmask_vec(setmask_vec),
  .stat_q     (stat_q),
  .mask_q     (mask_q),
  .irq        (irq),
  .ch_enable  (ch_enable),
  .ev_done    (ev_done),
  .go_wr      (go_wr),
  .halt_wr    (halt_wr),
  .rd_src     (rd_src),
  .src_irq_ev (src_irq_ev),
  .cnt_src    (cnt_src)
);

// File: tb/tb_dmach_regs.sv
module tb_dmach_regs;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 20000;
  localparam int NV = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ev_done = 1'b0;
  logic [2:0]  ev_err = '0;
  logic        src_irq_ev = 1'b0, dst_irq_ev = 1'b0;
  logic        byte_vld = 1'b0;
  logic [15:0] byte_inc = '0;
  logic [63:0] cur_src_pay = '0, cur_dst_pay = '0, cur_src_dscr = '0, cur_dst_dscr = '0;
  logic        irq, ch_enable;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dmach_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_done(ev_done), .ev_err(ev_err),
    .src_irq_ev(src_irq_ev), .dst_irq_ev(dst_irq_ev), .byte_vld(byte_vld),
    .byte_inc(byte_inc), .cur_src_pay(cur_src_pay), .cur_dst_pay(cur_dst_pay),
    .cur_src_dscr(cur_src_dscr), .cur_dst_dscr(cur_dst_dscr),
    .irq(irq), .ch_enable(ch_enable)
  );

  // row: {op (0 write, 1 read-expect), index, data, requirement}
  localparam logic [40:0] TBL [0:NV-1] = '{
    {1'b1, 4'd1, 32'hF, 4'd1},  // R1 mask resets to all ones
    {1'b1, 4'd0, 32'h0, 4'd1},  // R1 status clear
    {1'b1, 4'd4, 32'h0, 4'd1},  // R1 channel idle
    {1'b1, 4'd5, 32'h0, 4'd1},  // R1 byte total zero
    {1'b0, 4'd2, 32'h5, 4'd5},  // R5 unmask bits 0,2
    {1'b1, 4'd1, 32'hA, 4'd5},
    {1'b1, 4'd2, 32'h0, 4'd5},  // R5 unmask reads zero
    {1'b0, 4'd3, 32'h1, 4'd6},  // R6 block bit 0
    {1'b1, 4'd1, 32'hB, 4'd6},
    {1'b1, 4'd3, 32'h0, 4'd6},  // R6 block reads zero
    {1'b0, 4'd3, 32'h0, 4'd6},  // R6 zero data changes nothing
    {1'b1, 4'd1, 32'hB, 4'd6},
    {1'b0, 4'd2, 32'hF, 4'd5},  // R5 unmask all
    {1'b1, 4'd1, 32'h0, 4'd5},
    {1'b0, 4'd4, 32'h1, 4'd7},  // R7 start
    {1'b1, 4'd4, 32'h1, 4'd7},
    {1'b0, 4'd4, 32'h3, 4'd7},  // R7 stop wins over start
    {1'b1, 4'd4, 32'h0, 4'd7},
    {1'b0, 4'd4, 32'h1, 4'd7},
    {1'b0, 4'd4, 32'h0, 4'd7},  // R7 no command bits
    {1'b1, 4'd4, 32'h1, 4'd7},
    {1'b0, 4'd4, 32'h2, 4'd7},  // R7 stop
    {1'b1, 4'd4, 32'h0, 4'd7}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] got);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 got = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] got;
    rd_reg(a, got);
    chk(tag, got, exp);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 enable low", {31'd0, ch_enable}, 32'd0);
    rd_chk(4'd6, 32'd0, "R1 src count");
    rd_chk(4'd7, 32'd0, "R1 dst count");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][40] == 1'b0) wr_reg(TBL[i][39:36], TBL[i][35:4]);
      else begin
        rd_reg(TBL[i][39:36], got);
        chk($sformatf("R%0d row %0d", TBL[i][3:0], i), got, TBL[i][35:4]);
      end
    end

    // R3 / R4: done event with everything unmasked
    @(negedge clk); ev_done = 1'b1;
    @(negedge clk); ev_done = 1'b0;
    rd_chk(4'd0, 32'h1, "R3 done sets status");
    chk("R4 irq on unmasked", {31'd0, irq}, 32'd1);
    wr_reg(4'd3, 32'h1);
    chk("R4 irq off when masked", {31'd0, irq}, 32'd0);
    wr_reg(4'd2, 32'h1);
    chk("R4 irq back on", {31'd0, irq}, 32'd1);
    wr_reg(4'd0, 32'h1);
    rd_chk(4'd0, 32'h0, "R2 write one clears");
    chk("R4 irq off after clear", {31'd0, irq}, 32'd0);

    @(negedge clk); ev_err = 3'b010;
    @(negedge clk); ev_err = 3'b000;
    rd_chk(4'd0, 32'h4, "R3 error bit 2");
    wr_reg(4'd0, 32'hFFFF_FFF0);
    rd_chk(4'd0, 32'h4, "R2 undefined bits ignored");
    @(negedge clk); wr_en = 1'b1; addr = 4'd0; wdata = 32'h4; ev_err = 3'b010;
    @(negedge clk); wr_en = 1'b0; ev_err = 3'b000;
    rd_chk(4'd0, 32'h4, "R3 event beats clear");
    wr_reg(4'd0, 32'h4);
    rd_chk(4'd0, 32'h0, "R2 cleared");

    // R7 self-clear on done, and start coinciding with done
    wr_reg(4'd4, 32'h1);
    @(negedge clk); ev_done = 1'b1;
    @(negedge clk); ev_done = 1'b0;
    rd_chk(4'd4, 32'h0, "R7 done clears enable");
    @(negedge clk); wr_en = 1'b1; addr = 4'd4; wdata = 32'h1; ev_done = 1'b1;
    @(negedge clk); wr_en = 1'b0; ev_done = 1'b0;
    chk("R7 start beats done", {31'd0, ch_enable}, 32'd1);
    wr_reg(4'd4, 32'h2);
    wr_reg(4'd0, 32'hF);

    // R8 counters
    @(negedge clk); src_irq_ev = 1'b1;
    repeat (3) @(negedge clk);
    src_irq_ev = 1'b0;
    rd_chk(4'd6, 32'd3, "R8 src count");
    rd_chk(4'd6, 32'd0, "R8 src cleared by read");
    @(negedge clk); rd_en = 1'b1; addr = 4'd6; src_irq_ev = 1'b1;
    #1 chk("R8 read value with coincident event", rdata, 32'd0);
    @(negedge clk); rd_en = 1'b0; src_irq_ev = 1'b0;
    rd_chk(4'd6, 32'd1, "R8 coincident event kept");
    @(negedge clk); dst_irq_ev = 1'b1;
    @(negedge clk); dst_irq_ev = 1'b0;
    @(negedge clk); dst_irq_ev = 1'b1;
    @(negedge clk); dst_irq_ev = 1'b0;
    rd_chk(4'd7, 32'd2, "R8 dst count");
    @(negedge clk); src_irq_ev = 1'b1;
    repeat (300) @(negedge clk);
    src_irq_ev = 1'b0;
    rd_chk(4'd6, 32'd255, "R8 saturates");
    rd_chk(4'd6, 32'd0, "R8 cleared after saturation");

    // R9 byte total
    @(negedge clk); byte_vld = 1'b1; byte_inc = 16'd100;
    @(negedge clk); byte_inc = 16'd28;
    @(negedge clk); byte_vld = 1'b0;
    rd_chk(4'd5, 32'd128, "R9 accumulate");
    wr_reg(4'd5, 32'd127);
    rd_chk(4'd5, 32'd128, "R9 mismatched write ignored");
    wr_reg(4'd5, 32'd128);
    rd_chk(4'd5, 32'd0, "R9 matching write clears");
    @(negedge clk); byte_vld = 1'b1; byte_inc = 16'd10;
    @(negedge clk); byte_vld = 1'b0;
    @(negedge clk); wr_en = 1'b1; addr = 4'd5; wdata = 32'd10; byte_vld = 1'b1; byte_inc = 16'd5;
    @(negedge clk); wr_en = 1'b0; byte_vld = 1'b0;
    rd_chk(4'd5, 32'd5, "R9 increment during clear kept");

    // R10 address readback
    cur_src_pay  = 64'h1111_2222_3333_4444;
    cur_dst_pay  = 64'h5555_6666_7777_8888;
    cur_src_dscr = 64'h9999_AAAA_BBBB_CCCC;
    cur_dst_dscr = 64'hDDDD_EEEE_FFFF_0123;
    rd_chk(4'd8,  32'h3333_4444, "R10 src pay lo");
    rd_chk(4'd9,  32'h1111_2222, "R10 src pay hi");
    rd_chk(4'd10, 32'h7777_8888, "R10 dst pay lo");
    rd_chk(4'd11, 32'h5555_6666, "R10 dst pay hi");
    rd_chk(4'd12, 32'hBBBB_CCCC, "R10 src dscr lo");
    rd_chk(4'd13, 32'h9999_AAAA, "R10 src dscr hi");
    rd_chk(4'd14, 32'hFFFF_0123, "R10 dst dscr lo");
    rd_chk(4'd15, 32'hDDDD_EEEE, "R10 dst dscr hi");

    summary();
    $finish;
  end
endmodule